// File: doc/BRIEF.md
# Multi-Waveform Chirp Sequence Scheduler

This block sets the per-chirp timing of a pulsed radar. Each chirp has an active interval, during which the transmitter sweeps, and then a listen interval, during which echoes are received. The block drives the waveform class of each chirp, the sub-frame it belongs to and its position inside that sub-frame. It raises a strobe on the first cycle of every chirp and another on the first chirp of every frame.

There are two modes. In scan mode a frame is made of up to three sub-frames: short, medium and long waveforms, always in that order. Each sub-frame holds a fixed number of chirps, and an enable mask can leave any of them out. In track mode every chirp of the frame uses one waveform chosen by the host, and the host also sets how many chirps the frame holds. A frame-count watchdog returns the block to scan mode when the host stops sending track commands.

The host programs the block through a simple write port. Writes land in staged registers that have reset defaults. The scheduler copies the staged registers only when a frame starts, so the timing inside a frame never changes.

Top module: `chirp_sequencer`

## Requirements
- R1: `wave_sel` uses 00 for short, 01 for medium and 10 for long, and it never shows 11. A write of 11 to the track-waveform register (address 2) is rejected: the register keeps its value and `cfg_err` goes high and stays high until reset.
- R2: A scan frame runs the short sub-frame, then the medium one, then the long one. Each holds SUB_CHIRPS chirps (default 16). `chirp_idx` counts 0 to SUB_CHIRPS-1 inside each sub-frame, and `sub_idx` equals the waveform class (0, 1, 2).
- R3: The 3-bit enable mask (address 1, bit 0 short, bit 1 medium, bit 2 long) resets to 111. A sub-frame whose bit is clear is skipped.
- R4: Reset chirp lengths are 100, 500 and 3000 cycles for short, medium and long (addresses 4, 5, 6).
- R5: Reset listen lengths are 17400, 17000 and 13700 cycles for short, medium and long (addresses 7, 8, 9).
- R6: Each chirp holds `chirp_on` for exactly its chirp length, then `listen_on` for exactly its listen length. The next chirp starts on the following cycle. `chirp_stb` marks the first `chirp_on` cycle.
- R7: `frame_stb` is high for one cycle, together with `chirp_stb`, on the first chirp of each frame only.
- R8: Mode code 11 (address 0; every other code means scan) selects track mode. Each frame then holds dwell chirps (address 3, reset 64) of the track waveform (address 2, reset 00), with `sub_idx` 0.
- R9: A frame in track mode that ends with no accepted track-waveform write since the previous frame end counts as silent. When WDOG_FRAMES (default 5) silent frames in a row have ended, the mode register becomes 00 and the next frame is a scan frame.
- R10: In scan mode with the mask at 000, no chirps are issued. A frame starts on the cycle after a nonzero mask is staged.
- R11: Registers written during a frame take effect from the next frame only.
- R12: During reset `chirp_on`, `listen_on`, `chirp_stb`, `frame_stb` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| chirp_on | output | 1 | Chirp-active interval |
| listen_on | output | 1 | Listen interval |
| wave_sel | output | 2 | Waveform class of the current chirp |
| sub_idx | output | 2 | Sub-frame index |
| chirp_idx | output | 9 | Chirp index within the sub-frame or dwell |
| chirp_stb | output | 1 | First cycle of a chirp |
| frame_stb | output | 1 | First cycle of a frame |
| cfg_err | output | 1 | Sticky flag for a rejected reserved waveform code |

## Verification
The hardest situation to reach from the ports is the watchdog fallback. It needs a run of track frames in which silent frames are counted, a track command that restarts the count partway through, and a rejected reserved-code write that must not count as a command. The stimulus lines each write up with a given frame by waiting for `frame_stb`. It makes the first track frame the long reset-default dwell, shortens the dwell for the frames after it, and then checks that exactly seven track frames appear before the scheduler falls silent in scan mode. The same frame-aligned writes check that a mid-frame change of timing and mask waits for the next frame, while the first frame still runs entirely on reset defaults.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int CSQ_LEN_W   = 16;
    localparam int CSQ_DWELL_W = 9;

    typedef enum logic [1:0] {
        WAVE_SHORT  = 2'b00,
        WAVE_MEDIUM = 2'b01,
        WAVE_LONG   = 2'b10,
        WAVE_RSVD   = 2'b11
    } wave_e;

    typedef enum logic [3:0] {
        A_MODE    = 4'd0,
        A_MASK    = 4'd1,
        A_TRKWAVE = 4'd2,
        A_DWELL   = 4'd3,
        A_CLEN_S  = 4'd4,
        A_CLEN_M  = 4'd5,
        A_CLEN_L  = 4'd6,
        A_LLEN_S  = 4'd7,
        A_LLEN_M  = 4'd8,
        A_LLEN_L  = 4'd9
    } addr_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHIRP  = 2'd1,
        PH_LISTEN = 2'd2
    } phase_e;

    typedef struct packed {
        logic                            track;
        logic [2:0]                      mask;
        wave_e                           trk_wave;
        logic [CSQ_DWELL_W-1:0]          dwell;
        logic [2:0][CSQ_LEN_W-1:0]       clen;
        logic [2:0][CSQ_LEN_W-1:0]       llen;
    } sched_cfg_t;

    function automatic logic [CSQ_LEN_W-1:0] pick_len(
        input logic [2:0][CSQ_LEN_W-1:0] a,
        input wave_e                     w
    );
        case (w)
            WAVE_MEDIUM: return a[1];
            WAVE_LONG:   return a[2];
            default:     return a[0];
        endcase
    endfunction

    // Counter load value: a programmed length of 0 behaves as 1
    function automatic logic [CSQ_LEN_W-1:0] load_of(input logic [CSQ_LEN_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

endpackage

// File: rtl/csq_regs.sv
module csq_regs
    import csq_pkg::*;
#(
    parameter int DEF_CLEN_S = 100,
    parameter int DEF_CLEN_M = 500,
    parameter int DEF_CLEN_L = 3000,
    parameter int DEF_LLEN_S = 17400,
    parameter int DEF_LLEN_M = 17000,
    parameter int DEF_LLEN_L = 13700,
    parameter int DEF_DWELL  = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [3:0]           addr_i,
    input  logic [CSQ_LEN_W-1:0] wdata_i,
    input  logic                 frame_end_i,
    input  logic                 fallback_i,
    output sched_cfg_t           cfg_o,
    output logic                 kick_o,
    output logic                 err_o
);

    typedef struct packed {
        logic [1:0]                mode;
        logic [2:0]                mask;
        wave_e                     trk_wave;
        logic [CSQ_DWELL_W-1:0]    dwell;
        logic [2:0][CSQ_LEN_W-1:0] clen;
        logic [2:0][CSQ_LEN_W-1:0] llen;
        logic                      kick;
        logic                      err;
    } regs_t;

    regs_t r_d, r_q;
    logic  trk_wr, trk_bad;

    assign trk_wr  = we_i && (addr_i == A_TRKWAVE);
    assign trk_bad = trk_wr && (wdata_i[1:0] == WAVE_RSVD);

    always_comb begin
        r_d = r_q;
        if (frame_end_i) r_d.kick = 1'b0;
        if (fallback_i)  r_d.mode = 2'b00;
        if (we_i) begin
            case (addr_i)
                A_MODE:    r_d.mode  = wdata_i[1:0];
                A_MASK:    r_d.mask  = wdata_i[2:0];
                A_TRKWAVE: begin
                    if (trk_bad) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.trk_wave = wave_e'(wdata_i[1:0]);
                        r_d.kick     = 1'b1;
                    end
                end
                A_DWELL:   r_d.dwell   = wdata_i[CSQ_DWELL_W-1:0];
                A_CLEN_S:  r_d.clen[0] = wdata_i;
                A_CLEN_M:  r_d.clen[1] = wdata_i;
                A_CLEN_L:  r_d.clen[2] = wdata_i;
                A_LLEN_S:  r_d.llen[0] = wdata_i;
                A_LLEN_M:  r_d.llen[1] = wdata_i;
                A_LLEN_L:  r_d.llen[2] = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode     <= 2'b00;
            r_q.mask     <= 3'b111;
            r_q.trk_wave <= WAVE_SHORT;
            r_q.dwell    <= CSQ_DWELL_W'(DEF_DWELL);
            r_q.clen[0]  <= CSQ_LEN_W'(DEF_CLEN_S);
            r_q.clen[1]  <= CSQ_LEN_W'(DEF_CLEN_M);
            r_q.clen[2]  <= CSQ_LEN_W'(DEF_CLEN_L);
            r_q.llen[0]  <= CSQ_LEN_W'(DEF_LLEN_S);
            r_q.llen[1]  <= CSQ_LEN_W'(DEF_LLEN_M);
            r_q.llen[2]  <= CSQ_LEN_W'(DEF_LLEN_L);
            r_q.kick     <= 1'b0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cfg_o.track    = (r_q.mode == 2'b11);
        cfg_o.mask     = r_q.mask;
        cfg_o.trk_wave = r_q.trk_wave;
        cfg_o.dwell    = r_q.dwell;
        cfg_o.clen     = r_q.clen;
        cfg_o.llen     = r_q.llen;
    end

    assign kick_o = r_q.kick || (trk_wr && !trk_bad);
    assign err_o  = r_q.err;

    assert_err_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_rsvd_rejected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trk_bad |=> (err_o && $stable(cfg_o.trk_wave)));

endmodule

// File: rtl/csq_watchdog.sv
module csq_watchdog #(
    parameter int WDOG_FRAMES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track_act_i,
    input  logic frame_end_i,
    input  logic kick_i,
    output logic fallback_o
);

    localparam int CW = $clog2(WDOG_FRAMES + 1);

    typedef struct packed {
        logic [CW-1:0] silent;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        w_d        = w_q;
        fallback_o = 1'b0;
        if (!track_act_i) begin
            w_d.silent = '0;
        end else if (frame_end_i) begin
            if (kick_i) begin
                w_d.silent = '0;
            end else if (w_q.silent == CW'(WDOG_FRAMES - 1)) begin
                fallback_o = 1'b1;
                w_d.silent = '0;
            end else begin
                w_d.silent = w_q.silent + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assert_silent_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.silent < CW'(WDOG_FRAMES));

endmodule

// File: rtl/csq_core.sv
module csq_core
    import csq_pkg::*;
#(
    parameter int SUB_CHIRPS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  sched_cfg_t             cfg_i,
    input  logic                   fallback_i,
    output logic                   chirp_on_o,
    output logic                   listen_on_o,
    output logic [1:0]             wave_o,
    output logic [1:0]             sub_o,
    output logic [CSQ_DWELL_W-1:0] idx_o,
    output logic                   chirp_stb_o,
    output logic                   frame_stb_o,
    output logic                   frame_end_o,
    output logic                   track_act_o
);

    localparam int IW = CSQ_DWELL_W;

    typedef struct packed {
        phase_e                 phase;
        logic [CSQ_LEN_W-1:0]   cnt;
        logic [IW-1:0]          idx;
        logic [1:0]             sub;
        wave_e                  wave;
        sched_cfg_t             act;
        logic                   cstb;
        logic                   fstb;
    } core_t;

    core_t c_d, c_q;
    logic  last_chirp, more_sub, start_frame;
    logic [1:0] nxt_sub, first_sub;

    always_comb begin
        if (c_q.act.track)
            last_chirp = ({1'b0, c_q.idx} + 1'b1) >= {1'b0, c_q.act.dwell};
        else
            last_chirp = (c_q.idx == IW'(SUB_CHIRPS - 1));

        more_sub = !c_q.act.track &&
                   (((c_q.sub == 2'd0) && (c_q.act.mask[1] || c_q.act.mask[2])) ||
                    ((c_q.sub == 2'd1) && c_q.act.mask[2]));
        nxt_sub  = ((c_q.sub == 2'd0) && c_q.act.mask[1]) ? 2'd1 : 2'd2;

        first_sub = cfg_i.mask[0] ? 2'd0 : (cfg_i.mask[1] ? 2'd1 : 2'd2);

        frame_end_o = (c_q.phase == PH_LISTEN) && (c_q.cnt == '0) && last_chirp && !more_sub;
        start_frame = (c_q.phase == PH_IDLE) || frame_end_o;

        c_d      = c_q;
        c_d.cstb = 1'b0;
        c_d.fstb = 1'b0;

        case (c_q.phase)
            PH_CHIRP: begin
                if (c_q.cnt == '0) begin
                    c_d.phase = PH_LISTEN;
                    c_d.cnt   = load_of(pick_len(c_q.act.llen, c_q.wave));
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            PH_LISTEN: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (!last_chirp) begin
                    c_d.idx   = c_q.idx + 1'b1;
                    c_d.phase = PH_CHIRP;
                    c_d.cstb  = 1'b1;
                    c_d.cnt   = load_of(pick_len(c_q.act.clen, c_q.wave));
                end else if (more_sub) begin
                    c_d.sub   = nxt_sub;
                    c_d.wave  = wave_e'(nxt_sub);
                    c_d.idx   = '0;
                    c_d.phase = PH_CHIRP;
                    c_d.cstb  = 1'b1;
                    c_d.cnt   = load_of(pick_len(c_q.act.clen, wave_e'(nxt_sub)));
                end
            end
            default: ;
        endcase

        if (start_frame) begin
            c_d.act       = cfg_i;
            c_d.act.track = cfg_i.track && !fallback_i;
            c_d.idx       = '0;
            if (c_d.act.track) begin
                c_d.sub   = 2'd0;
                c_d.wave  = cfg_i.trk_wave;
                c_d.phase = PH_CHIRP;
                c_d.cstb  = 1'b1;
                c_d.fstb  = 1'b1;
                c_d.cnt   = load_of(pick_len(cfg_i.clen, cfg_i.trk_wave));
            end else if (cfg_i.mask != 3'b000) begin
                c_d.sub   = first_sub;
                c_d.wave  = wave_e'(first_sub);
                c_d.phase = PH_CHIRP;
                c_d.cstb  = 1'b1;
                c_d.fstb  = 1'b1;
                c_d.cnt   = load_of(pick_len(cfg_i.clen, wave_e'(first_sub)));
            end else begin
                c_d.phase = PH_IDLE;
                c_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.phase <= PH_IDLE;
            c_q.wave  <= WAVE_SHORT;
        end else begin
            c_q <= c_d;
        end
    end

    assign chirp_on_o  = (c_q.phase == PH_CHIRP);
    assign listen_on_o = (c_q.phase == PH_LISTEN);
    assign wave_o      = c_q.wave;
    assign sub_o       = c_q.sub;
    assign idx_o       = c_q.idx;
    assign chirp_stb_o = c_q.cstb;
    assign frame_stb_o = c_q.fstb;
    assign track_act_o = c_q.act.track;

    assert_no_rsvd_wave_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chirp_on_o || listen_on_o) |-> (wave_o != WAVE_RSVD));

    assert_listen_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_on_o |=> (chirp_on_o || listen_on_o));

    assert_stb_in_chirp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_stb_o |-> chirp_on_o);

    assert_wave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (listen_on_o && !frame_end_o) |=> (chirp_stb_o || $stable(wave_o)));

    assert_frame_stb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_o |-> (chirp_stb_o && (idx_o == '0)));

    assert_fallback_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_i |=> !track_act_o);

endmodule

// File: rtl/chirp_sequencer.sv
module chirp_sequencer
    import csq_pkg::*;
#(
    parameter int SUB_CHIRPS  = 16,
    parameter int WDOG_FRAMES = 5,
    parameter int DEF_CLEN_S  = 100,
    parameter int DEF_CLEN_M  = 500,
    parameter int DEF_CLEN_L  = 3000,
    parameter int DEF_LLEN_S  = 17400,
    parameter int DEF_LLEN_M  = 17000,
    parameter int DEF_LLEN_L  = 13700,
    parameter int DEF_DWELL   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic        chirp_on,
    output logic        listen_on,
    output logic [1:0]  wave_sel,
    output logic [1:0]  sub_idx,
    output logic [8:0]  chirp_idx,
    output logic        chirp_stb,
    output logic        frame_stb,
    output logic        cfg_err
);

    sched_cfg_t cfg;
    logic       kick, fallback, frame_end, track_act;

    csq_regs #(
        .DEF_CLEN_S (DEF_CLEN_S),
        .DEF_CLEN_M (DEF_CLEN_M),
        .DEF_CLEN_L (DEF_CLEN_L),
        .DEF_LLEN_S (DEF_LLEN_S),
        .DEF_LLEN_M (DEF_LLEN_M),
        .DEF_LLEN_L (DEF_LLEN_L),
        .DEF_DWELL  (DEF_DWELL)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we),
        .addr_i      (cfg_addr),
        .wdata_i     (cfg_wdata),
        .frame_end_i (frame_end),
        .fallback_i  (fallback),
        .cfg_o       (cfg),
        .kick_o      (kick),
        .err_o       (cfg_err)
    );

    csq_watchdog #(
        .WDOG_FRAMES (WDOG_FRAMES)
    ) i_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .track_act_i (track_act),
        .frame_end_i (frame_end),
        .kick_i      (kick),
        .fallback_o  (fallback)
    );

    csq_core #(
        .SUB_CHIRPS (SUB_CHIRPS)
    ) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .fallback_i  (fallback),
        .chirp_on_o  (chirp_on),
        .listen_on_o (listen_on),
        .wave_o      (wave_sel),
        .sub_o       (sub_idx),
        .idx_o       (chirp_idx),
        .chirp_stb_o (chirp_stb),
        .frame_stb_o (frame_stb),
        .frame_end_o (frame_end),
        .track_act_o (track_act)
    );

endmodule

// File: tb/test_chirp_sequencer.sv
module test_chirp_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int SUBN       = 2;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        chirp_on, listen_on, chirp_stb, frame_stb, cfg_err;
    logic [1:0]  wave_sel, sub_idx;
    logic [8:0]  chirp_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    chirp_sequencer #(.SUB_CHIRPS(SUBN)) i_chirp_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .chirp_on  (chirp_on),
        .listen_on (listen_on),
        .wave_sel  (wave_sel),
        .sub_idx   (sub_idx),
        .chirp_idx (chirp_idx),
        .chirp_stb (chirp_stb),
        .frame_stb (frame_stb),
        .cfg_err   (cfg_err)
    );

    typedef struct {
        logic       fs;
        logic [1:0] wave;
        logic [1:0] sub;
        int         idx;
        int         cl;
        int         ll;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_sub(input logic [1:0] w, input logic [1:0] s, input int n,
                            input int cl, input int ll, input bit first);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.fs = first && (i == 0);
            e.wave = w; e.sub = s; e.idx = i; e.cl = cl; e.ll = ll;
            exp_q.push_back(e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!frame_stb);
    endtask

    task automatic quiet_window(input string req);
        int seen;
        do @(negedge clk); while (exp_q.size() != 0 || chirp_on || listen_on);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (chirp_on || listen_on) seen++;
        end
        check(seen == 0, req, "active cycles while idle", seen, 0);
    endtask

    // Monitor: pops one expected chirp per chirp_stb and measures both phases
    exp_t cur;
    bit   rec = 0;
    int   cc = 0, lc = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rec && lc > 0 && !listen_on) begin
                check(cc == cur.cl, "R4/R5/R6/R11", "chirp length", cc, cur.cl);
                check(lc == cur.ll, "R4/R5/R6/R11", "listen length", lc, cur.ll);
                rec = 0;
            end
            if (chirp_stb) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9/R10", "unexpected chirp wave", int'(wave_sel), -1);
                    rec = 0;
                end else begin
                    cur = exp_q.pop_front();
                    check(frame_stb == cur.fs, "R7", "frame_stb", int'(frame_stb), int'(cur.fs));
                    check(wave_sel == cur.wave, "R1/R2/R3/R8/R9", "wave_sel",
                          int'(wave_sel), int'(cur.wave));
                    check(sub_idx == cur.sub, "R2/R3/R8", "sub_idx", int'(sub_idx), int'(cur.sub));
                    check(int'(chirp_idx) == cur.idx, "R2/R8", "chirp_idx",
                          int'(chirp_idx), cur.idx);
                    rec = 1; cc = 0; lc = 0;
                end
            end
            if (rec && chirp_on)  cc++;
            if (rec && listen_on) lc++;
        end
    end

    initial begin : watchdog_proc
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!chirp_on && !listen_on, "R12", "phase outputs in reset",
              int'({chirp_on, listen_on}), 0);
        check(!chirp_stb && !frame_stb, "R12", "strobes in reset",
              int'({chirp_stb, frame_stb}), 0);
        check(!cfg_err, "R12", "cfg_err in reset", int'(cfg_err), 0);

        // Frame 1 on reset defaults, all three sub-frames (R3 R4 R5)
        push_sub(2'b00, 2'd0, SUBN, 100, 17400, 1);
        push_sub(2'b01, 2'd1, SUBN, 500, 17000, 0);
        push_sub(2'b10, 2'd2, SUBN, 3000, 13700, 0);
        rst_n = 1'b1;

        wait_frame();
        // R11: mid-frame writes must not disturb frame 1
        wr(4'd4, 16'd3); wr(4'd5, 16'd5); wr(4'd6, 16'd7);
        wr(4'd7, 16'd4); wr(4'd8, 16'd6); wr(4'd9, 16'd8);
        wr(4'd1, 16'b101);
        // R3: medium skipped in frame 2
        push_sub(2'b00, 2'd0, SUBN, 3, 4, 1);
        push_sub(2'b10, 2'd2, SUBN, 7, 8, 0);

        wait_frame();
        wr(4'd1, 16'b000);
        quiet_window("R10");

        // R8: track on long waveform, default dwell 64 in the first frame
        push_sub(2'b10, 2'd0, 64, 7, 8, 1);
        for (int f = 0; f < 6; f++) push_sub(2'b10, 2'd0, 3, 7, 8, 1);
        wr(4'd2, 16'd2);
        wr(4'd0, 16'd3);
        wait_frame();
        wr(4'd3, 16'd3);
        wait_frame();
        wr(4'd2, 16'd2);              // track command restarts the silent count
        wait_frame();
        wait_frame();
        check(!cfg_err, "R1", "cfg_err before reserved write", int'(cfg_err), 0);
        wr(4'd2, 16'd3);              // reserved code, rejected, not a command
        check(cfg_err, "R1", "cfg_err after reserved write", int'(cfg_err), 1);
        // R9: seven track frames, then scan with mask 000 leaves it idle
        quiet_window("R9");

        // R9 R10: back in scan, a nonzero mask starts short frames
        push_sub(2'b00, 2'd0, SUBN, 3, 4, 1);
        wr(4'd1, 16'b001);
        wait_frame();
        wr(4'd1, 16'b000);
        quiet_window("R10");
        check(cfg_err, "R1", "cfg_err sticky", int'(cfg_err), 1);
        check(exp_q.size() == 0, "R9", "expected chirps left", exp_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule